// File: doc/BRIEF.md
# Interval Timer with Square-Wave Output

This block is a down-counting interval timer with a reload latch. Software-side logic loads the latch one byte at a time through plain write strobes. A start strobe writes the upper byte and copies the whole latch into the counter. The counter then decrements once per clock after a short start delay. When it passes below zero it raises an interrupt-set pulse, but only if it was armed by a load.

A two-bit mode input selects how the timer behaves. In the one-shot modes it fires once and then wraps and keeps counting. In the continuous modes it reloads from the latch and fires on every pass. Either of these can also drive a single output bit. In the one-shot variant the bit acts as a pulse that goes low at start and high when the count reaches zero. In the continuous variant the bit toggles at every zero, which gives a square wave with a period of twice (latch + 1) clocks.

The actions that happen at zero take place one step before underflow. The reload and the interrupt request happen on the underflow step itself. The interrupt request then passes through one extra clock before it appears at the output.

Top module: `wave_interval_timer`

## Requirements
- R1: Reset sets the counter and the reload latch to all ones, drives the wave output low and the interrupt pulse low. A start write after reset that has no low-byte write therefore loads 0x00FF when the upper data byte is zero.
- R2: In mode 2'b11 (continuous with wave), the wave output inverts on the clock at which the count steps from 1 to 0.
- R3: In mode 2'b10 (one-shot with wave), the wave output goes high on the clock at which the count steps from 1 to 0. A start write in either mode 2'b10 or 2'b11 drives the wave output low on the clock after the load.
- R4: An interrupt is produced on underflow (count 0 stepping down) only while the timer is armed. Each load arms it and each interrupt disarms it, so a one-shot mode gives exactly one interrupt per start.
- R5: In the continuous modes (mode bit 0 = 1), underflow reloads the counter from the latch and re-arms it. With latch value L the interrupts repeat every L+1 clocks.
- R6: In the one-shot modes (mode bit 0 = 0), underflow wraps the counter to all ones and counting continues.
- R7: The interrupt pulse is high for one clock, two clocks after the clock on which the underflow step happens.
- R8: A start write loads the counter with {data byte, latch low byte}, arms the timer and holds the count for START_DLY clocks before the first decrement.
- R9: Writes to the latch low byte or latch high byte without the start strobe leave the counter decrementing by one per clock.
- R10: In modes 2'b00 and 2'b01, the wave output keeps its value, including across zero and across start writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 one-shot, 01 continuous, 10 one-shot with wave pulse, 11 continuous with wave toggle |
| wdata_i | input | BYTE_W | Write data byte |
| wr_lo_i | input | 1 | Write latch low byte |
| wr_hi_i | input | 1 | Write latch high byte only |
| wr_start_i | input | 1 | Write latch high byte and load the counter |
| count_o | output | 2*BYTE_W | Current counter value |
| irq_o | output | 1 | One-clock interrupt-set pulse |
| wave_o | output | 1 | Wave / pulse output bit |

## Verification
The timer is run in each of the four modes, with several latch values. A continuous run with latch 5 separates reload-from-latch from wrap-to-all-ones through the spacing of the interrupts and the value after underflow. A continuous run with latch 3 in wave mode shows that toggling happens at zero rather than at underflow. The one-shot wave runs show the forced-low at start apart from the rise at zero, and show that a second interrupt is missing. A run with latch zero exposes back-to-back interrupts. A mode-00 start with the wave bit already high shows that the wave bit is left alone.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
   typedef enum logic [1:0] {
      IVT_ONESHOT      = 2'b00,
      IVT_CONT         = 2'b01,
      IVT_ONESHOT_WAVE = 2'b10,
      IVT_CONT_WAVE    = 2'b11
   } ivt_mode_e;

   function automatic logic mode_is_cont(input logic [1:0] m);
      return m[0];
   endfunction

   function automatic logic mode_has_wave(input logic [1:0] m);
      return m[1];
   endfunction
endpackage

// File: rtl/ivt_latch.sv
module ivt_latch #(
   parameter int BYTE_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [BYTE_W-1:0]     wdata_i,
   input  logic                  wr_lo_i,
   input  logic                  wr_hi_i,
   output logic [2*BYTE_W-1:0]   latch_o,
   output logic [2*BYTE_W-1:0]   load_val_o
);
   localparam int CNT_W = 2 * BYTE_W;

   logic [BYTE_W-1:0] lo_q, hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '1;
         hi_q <= '1;
      end else begin
         if (wr_lo_i) lo_q <= wdata_i;
         if (wr_hi_i) hi_q <= wdata_i;
      end
   end

   assign latch_o    = {hi_q, lo_q};
   // value taken by the counter on a start write: new upper byte, held lower byte
   assign load_val_o = {wdata_i, lo_q};

   a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_lo_i && !wr_hi_i) |=> (latch_o == $past(latch_o)));

   if (CNT_W != 2 * BYTE_W) begin : g_bad_w
      $error("ivt_latch: width mismatch");
   end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
   parameter int CNT_W     = 16,
   parameter int START_DLY = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CNT_W-1:0]  load_val_i,
   input  logic [CNT_W-1:0]  reload_val_i,
   input  logic              cont_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              zero_o,
   output logic              fire_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;
   logic             busy;
   logic             step;
   logic             under;

   if (START_DLY > 0) begin : g_dly
      localparam int DLY_W = $clog2(START_DLY + 1);
      logic [DLY_W-1:0] dly_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             dly_q <= '0;
         else if (load_i)        dly_q <= DLY_W'(START_DLY);
         else if (dly_q != '0)   dly_q <= dly_q - 1'b1;
      end
      assign busy = (dly_q != '0);
   end else begin : g_nodly
      assign busy = 1'b0;
   end

   assign step   = !load_i && !busy;
   assign under  = step && (cnt_q == '0);
   assign zero_o = step && (cnt_q == CNT_W'(1));
   assign fire_o = under && armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '1;
         armed_q <= 1'b0;
      end else if (load_i) begin
         cnt_q   <= load_val_i;
         armed_q <= 1'b1;
      end else if (step) begin
         if (under) begin
            if (cont_i) begin
               cnt_q   <= reload_val_i;
               armed_q <= 1'b1;
            end else begin
               cnt_q   <= '1;
               armed_q <= 1'b0;
            end
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign cnt_o = cnt_q;

   a_r8_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (armed_q && cnt_q == $past(load_val_i)));
   a_r8_delay_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !load_i) |=> (cnt_q == $past(cnt_q)));
   a_r4_fire_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_o && !cont_i) |=> !armed_q);
   a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (under && cont_i) |=> (armed_q && cnt_q == $past(reload_val_i)));
   a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (under && !cont_i) |=> (cnt_q == '1));

   if (START_DLY < 0) begin : g_bad_dly
      $error("ivt_counter: START_DLY must not be negative");
   end
endmodule

// File: rtl/ivt_wave.sv
module ivt_wave
   import ivt_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  mode_i,
   input  logic        load_i,
   input  logic        zero_i,
   output logic        wave_o
);
   logic clr_q;
   logic wave_q;
   logic wave_n;

   always_comb begin
      wave_n = wave_q;
      if (clr_q) wave_n = 1'b0;
      if (zero_i) begin
         if (mode_i == IVT_CONT_WAVE)         wave_n = ~wave_n;
         else if (mode_i == IVT_ONESHOT_WAVE) wave_n = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_q  <= 1'b0;
         wave_q <= 1'b0;
      end else begin
         clr_q  <= load_i && mode_has_wave(mode_i);
         wave_q <= wave_n;
      end
   end

   assign wave_o = wave_q;

   a_r2_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_i && mode_i == IVT_CONT_WAVE && !clr_q) |=> (wave_o != $past(wave_o)));
   a_r3_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_i && mode_i == IVT_ONESHOT_WAVE) |=> wave_o);
   a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_q && !zero_i) |=> !wave_o);
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i[1] && !clr_q) |=> (wave_o == $past(wave_o)));
endmodule

// File: rtl/wave_interval_timer.sv
module wave_interval_timer
   import ivt_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int START_DLY = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            mode_i,
   input  logic [BYTE_W-1:0]     wdata_i,
   input  logic                  wr_lo_i,
   input  logic                  wr_hi_i,
   input  logic                  wr_start_i,
   output logic [2*BYTE_W-1:0]   count_o,
   output logic                  irq_o,
   output logic                  wave_o
);
   localparam int CNT_W = 2 * BYTE_W;

   logic [CNT_W-1:0] latch;
   logic [CNT_W-1:0] load_val;
   logic             zero;
   logic             fire;
   logic             pend_q;
   logic             irq_q;

   ivt_latch #(.BYTE_W(BYTE_W)) latch_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wdata_i    (wdata_i),
      .wr_lo_i    (wr_lo_i),
      .wr_hi_i    (wr_hi_i | wr_start_i),
      .latch_o    (latch),
      .load_val_o (load_val)
   );

   ivt_counter #(.CNT_W(CNT_W), .START_DLY(START_DLY)) counter_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (wr_start_i),
      .load_val_i   (load_val),
      .reload_val_i (latch),
      .cont_i       (mode_is_cont(mode_i)),
      .cnt_o        (count_o),
      .zero_o       (zero),
      .fire_o       (fire)
   );

   ivt_wave wave_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (mode_i),
      .load_i (wr_start_i),
      .zero_i (zero),
      .wave_o (wave_o)
   );

   // underflow request waits one clock in pend_q before reaching the output
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         pend_q <= fire;
         irq_q  <= pend_q;
      end
   end

   assign irq_o = irq_q;

   a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |=> irq_o);
   a_r7_irq_only_after_pend: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q |=> !irq_o);

   if (BYTE_W < 2) begin : g_bad_byte
      $error("wave_interval_timer: BYTE_W must be at least 2");
   end
endmodule

// File: tb/wave_interval_timer_tb.sv
module wave_interval_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_i = 2'b00;
   logic [7:0]  wdata_i = 8'h00;
   logic        wr_lo_i = 1'b0;
   logic        wr_hi_i = 1'b0;
   logic        wr_start_i = 1'b0;
   logic [15:0] count_o;
   logic        irq_o;
   logic        wave_o;

   int ecnt = 0;
   int errs = 0;
   int checks = 0;
   bit done = 1'b0;
   int exp_q[$];

   always #4 clk = ~clk;
   always @(posedge clk) ecnt <= ecnt + 1;

   wave_interval_timer dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wdata_i(wdata_i),
      .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i), .wr_start_i(wr_start_i),
      .count_o(count_o), .irq_o(irq_o), .wave_o(wave_o)
   );

   task automatic check(input string req, input bit ok, input int act, input int expv);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h (edge %0d)", req, act, expv, ecnt);
      end
   endtask

   // monitor: every interrupt pulse must match the next expected edge (R7, R4)
   always @(negedge clk) begin
      if (rst_n && irq_o) begin
         if (exp_q.size() == 0) begin
            check("R4 unexpected irq", 1'b0, ecnt, -1);
         end else begin
            int e;
            e = exp_q.pop_front();
            check("R7 irq edge", ecnt == e, ecnt, e);
         end
      end
   end

   task automatic at_edge(input int t);
      while (ecnt < t) @(negedge clk);
   endtask

   // called at a negedge; applies reset immediately
   task automatic do_reset();
      #1;
      rst_n = 1'b0;
      wr_lo_i = 0; wr_hi_i = 0; wr_start_i = 0;
      check("R4 missing irq", exp_q.size() == 0, exp_q.size(), 0);
      exp_q.delete();
      @(negedge clk);
      check("R1 reset count", count_o == 16'hFFFF, count_o, 16'hFFFF);
      check("R1 reset wave", wave_o == 1'b0, wave_o, 0);
      check("R1 reset irq", irq_o == 1'b0, irq_o, 0);
      #1;
      rst_n = 1'b1;
   endtask

   task automatic write_lo(input logic [1:0] m, input logic [7:0] d);
      @(negedge clk); #1;
      mode_i = m; wdata_i = d; wr_lo_i = 1'b1;
      @(negedge clk); #1;
      wr_lo_i = 1'b0;
   endtask

   task automatic start(input logic [1:0] m, input logic [7:0] d, output int e0);
      @(negedge clk); #1;
      mode_i = m; wdata_i = d; wr_start_i = 1'b1;
      e0 = ecnt + 1;
      @(negedge clk); #1;
      wr_start_i = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errs++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      int e0, e1, c0;
      @(negedge clk);
      do_reset();

      // S7: start without low-byte write uses reset latch low byte (R1, R8)
      start(2'b00, 8'h00, e0);
      at_edge(e0);
      check("R1 latch reset low byte", count_o == 16'h00FF, count_o, 16'h00FF);
      exp_q.push_back(e0 + 3 + 16'h00FF);
      at_edge(e0 + 10);
      exp_q.delete();
      do_reset();

      // S2: continuous, L=5, plus latch-only writes (R9, R8, R5)
      write_lo(2'b01, 8'h05);
      @(negedge clk);
      c0 = count_o;
      #1; wdata_i = 8'h00; wr_hi_i = 1'b1;
      @(negedge clk);
      check("R9 latch hi write no load", count_o == ((c0 - 1) & 16'hFFFF), count_o, (c0 - 1) & 16'hFFFF);
      #1; wr_hi_i = 1'b0;
      start(2'b01, 8'h00, e0);
      exp_q.push_back(e0 + 8);
      exp_q.push_back(e0 + 14);
      exp_q.push_back(e0 + 20);
      at_edge(e0);
      check("R8 load value", count_o == 16'd5, count_o, 5);
      at_edge(e0 + 1);
      check("R8 start delay hold", count_o == 16'd5, count_o, 5);
      at_edge(e0 + 2);
      check("R8 first decrement", count_o == 16'd4, count_o, 4);
      at_edge(e0 + 6);
      check("R5 reaches zero", count_o == 16'd0, count_o, 0);
      at_edge(e0 + 7);
      check("R5 reload from latch", count_o == 16'd5, count_o, 5);
      at_edge(e0 + 8);
      check("R5 counting after reload", count_o == 16'd4, count_o, 4);
      at_edge(e0 + 20);
      check("R10 wave unchanged mode 01", wave_o == 1'b0, wave_o, 0);
      at_edge(e0 + 22);
      do_reset();

      // S3: continuous with toggle, L=3 (R2)
      write_lo(2'b11, 8'h03);
      start(2'b11, 8'h00, e0);
      exp_q.push_back(e0 + 6);
      exp_q.push_back(e0 + 10);
      exp_q.push_back(e0 + 14);
      at_edge(e0 + 3);
      check("R2 wave before zero", wave_o == 1'b0, wave_o, 0);
      at_edge(e0 + 4);
      check("R2 toggle at first zero", wave_o == 1'b1, wave_o, 1);
      at_edge(e0 + 7);
      check("R2 no toggle at underflow", wave_o == 1'b1, wave_o, 1);
      at_edge(e0 + 8);
      check("R2 toggle at second zero", wave_o == 1'b0, wave_o, 0);
      at_edge(e0 + 12);
      check("R2 toggle at third zero", wave_o == 1'b1, wave_o, 1);
      at_edge(e0 + 15);
      do_reset();

      // S4: one-shot with pulse, L=4 (R3, R4, R6)
      write_lo(2'b10, 8'h04);
      start(2'b10, 8'h00, e0);
      exp_q.push_back(e0 + 7);
      at_edge(e0 + 4);
      check("R3 wave low before zero", wave_o == 1'b0, wave_o, 0);
      at_edge(e0 + 5);
      check("R3 wave high at zero", wave_o == 1'b1, wave_o, 1);
      at_edge(e0 + 12);
      start(2'b10, 8'h00, e1);
      exp_q.push_back(e1 + 7);
      at_edge(e1);
      check("R3 wave held in load clock", wave_o == 1'b1, wave_o, 1);
      at_edge(e1 + 1);
      check("R3 start drives wave low", wave_o == 1'b0, wave_o, 0);
      at_edge(e1 + 4);
      check("R3 wave still low", wave_o == 1'b0, wave_o, 0);
      at_edge(e1 + 5);
      check("R3 wave high again at zero", wave_o == 1'b1, wave_o, 1);
      at_edge(e1 + 6);
      check("R6 wrap to all ones", count_o == 16'hFFFF, count_o, 16'hFFFF);
      at_edge(e1 + 7);
      check("R6 keeps counting", count_o == 16'hFFFE, count_o, 16'hFFFE);
      at_edge(e1 + 30);
      check("R4 single irq per start", exp_q.size() == 0, exp_q.size(), 0);

      // S5: mode 00 with wave high, L=2 (R10, R4)
      write_lo(2'b00, 8'h02);
      start(2'b00, 8'h00, e0);
      exp_q.push_back(e0 + 5);
      at_edge(e0 + 1);
      check("R10 start leaves wave in mode 00", wave_o == 1'b1, wave_o, 1);
      at_edge(e0 + 4);
      check("R10 zero leaves wave in mode 00", wave_o == 1'b1, wave_o, 1);
      check("R6 wrap in mode 00", count_o == 16'hFFFF, count_o, 16'hFFFF);
      at_edge(e0 + 20);
      do_reset();

      // S6: continuous, L=0: back-to-back interrupts (R5, R7)
      write_lo(2'b01, 8'h00);
      start(2'b01, 8'h00, e0);
      for (int k = 3; k <= 7; k++) exp_q.push_back(e0 + k);
      at_edge(e0 + 7);
      do_reset();

      at_edge(ecnt + 3);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule